// File: doc/BRIEF.md
# Converter Start and Readout Bus Bridge

This block is glue logic between an 8-bit processor bus and a 10-bit successive-approximation converter. The converter has an active-low data-ready output and a blank/convert input. Driving blank/convert high blanks the converter and clears it. Driving it low starts a conversion. The converter then keeps its result on its data pins for as long as blank/convert stays low. Because of that, the bridge keeps no copy of the result. Read accesses are combinational selections of the converter's live data pins.

A processor write to the start select raises blank/convert through a self-clearing launch stage. The stage holds the line high for at least a programmed number of clocks and until the synchronized data-ready line has risen. It then drops the line, which starts the conversion. The stage counts as busy until data-ready falls again.

Three read selects return the following:
- the upper part of the result;
- the remaining lower part of the result;
- a status byte with the data-ready level, for polling, and a sticky overrun flag.

A start written while the bridge is busy is dropped, and it sets the overrun flag. A parameter picks between left-justified and right-justified packing of the result. All bus strobes are sampled on the bridge clock, so they must be synchronous to it.

Top module: `conv_bus_bridge`

## Requirements
- R1: While reset is asserted and right after it, `cvt_bc` is 0, `bus_oe` is 0 and `bus_rdata` is 0. The overrun flag is 0 and the bridge is idle.
- R2: The first clock edge that sees `sel_start_n`=0 and `bus_wr_n`=0 together, after either was high, launches a start when the bridge is idle. `cvt_bc` is 1 right after that edge. Holding the strobe low does not start again.
- R3: Once raised, `cvt_bc` stays 1 for at least MIN_PULSE clock cycles. It falls only at an edge where the synchronized data-ready line is high.
- R4: After `cvt_bc` falls, the bridge stays busy until the synchronized data-ready line is low. It then returns to idle and accepts a new start.
- R5: With RIGHT_JUST=0, a read of `sel_hi_n` returns result bits 9..2 on `bus_rdata[7:0]`.
- R6: With RIGHT_JUST=0, a read of `sel_lo_n` returns result bits 1..0 on `bus_rdata[7:6]`, with zeros in bits 5..0.
- R7: With RIGHT_JUST=1, the high read returns result bits 9..8 on `bus_rdata[1:0]` with zeros above. The low read returns result bits 7..0.
- R8: A read of `sel_stat_n` returns a status byte:
  - bit 7 is the synchronized data-ready level (1 means the line is high);
  - bit 0 is the overrun flag;
  - bits 6..1 are 0.
- R9: A start launched while the bridge is busy is ignored. `cvt_bc` and the conversion in progress are unaffected, and the overrun flag is set.
- R10: The overrun flag stays set until the first clock edge after a status read ends, and it clears at that edge. If a busy start arrives at the same edge, the flag stays set.
- R11: `bus_oe` is 1 and `bus_rdata` is driven only while `bus_rd_n`=0 with a select low. Otherwise both are 0. With several selects low, the priority is status, then high, then low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bridge clock; bus strobes are synchronous to it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_rd_n | input | 1 | Active-low bus read strobe |
| bus_wr_n | input | 1 | Active-low bus write strobe |
| sel_start_n | input | 1 | Decoded select of the start address, active low |
| sel_hi_n | input | 1 | Decoded select of the upper result word, active low |
| sel_lo_n | input | 1 | Decoded select of the lower result word, active low |
| sel_stat_n | input | 1 | Decoded select of the status byte, active low |
| bus_rdata | output | 8 | Read data toward the bus, 0 when not driving |
| bus_oe | output | 1 | High while the bridge drives read data |
| cvt_bc | output | 1 | Blank/convert line to the converter, high blanks it |
| cvt_rdy_n | input | 1 | Converter data-ready line, active low |
| cvt_data | input | 10 | Converter result pins |

## Verification
The overrun flag can be set by a start written while the bridge is busy in the same clock edge that clears it because a status read has ended. The bench provokes this during a conversion. It holds a status read and then, at one falling clock edge, releases the read strobe and asserts the start write. The flag must survive, so the next status read is expected to show bit 0 set, and the read after it must show the flag cleared. The ignored start in that case must also leave `cvt_bc` low and the result pins unchanged, which the later data reads confirm.

// File: rtl/cbb_pkg.sv
package cbb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LAUNCH = 2'd1,
    ST_CONV   = 2'd2
  } cbb_state_e;

  localparam int STAT_RDY_BIT = 7;
  localparam int STAT_OVR_BIT = 0;
endpackage

// File: rtl/cbb_sync.sv
module cbb_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= RST_VAL;
          else        chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= RST_VAL;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cbb_launch.sv
module cbb_launch
  import cbb_pkg::*;
#(
  parameter int MIN_PULSE = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_evt_i,
  input  logic rdy_line_i,
  input  logic ovr_clr_i,
  output logic bc_o,
  output logic busy_o,
  output logic ovr_o
);
  localparam int CNT_W = $clog2(MIN_PULSE + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MIN_PULSE - 1);

  cbb_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             bc_q, bc_d;
  logic             ovr_q, ovr_d;
  logic             cnt_en;
  logic             width_met;

  assign busy_o    = (state_q != ST_IDLE);
  assign width_met = (cnt_q == CNT_LAST);
  assign cnt_en    = (state_q == ST_LAUNCH) && !width_met;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_IDLE: begin
        if (start_evt_i) begin
          state_d = ST_LAUNCH;
          cnt_d   = '0;
        end
      end
      ST_LAUNCH: begin
        if (cnt_en) cnt_d = cnt_q + 1'b1;
        if (width_met && rdy_line_i) state_d = ST_CONV;
      end
      ST_CONV: begin
        if (!rdy_line_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
    bc_d  = (state_d == ST_LAUNCH);
    ovr_d = (start_evt_i && busy_o) || (ovr_q && !ovr_clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bc_q    <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bc_q    <= bc_d;
      ovr_q   <= ovr_d;
    end
  end

  assign bc_o  = bc_q;
  assign ovr_o = ovr_q;

  // Checker state: length of the current high run of the blank/convert line
  int unsigned hi_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hi_run <= 0;
    else if (bc_q) hi_run <= hi_run + 1;
    else           hi_run <= 0;
  end

  // R2
  launch_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt_i && !busy_o) |=> bc_o);

  // R3
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bc_o) |-> (hi_run >= MIN_PULSE));

  // R3
  release_on_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bc_o) |-> $past(rdy_line_i));

  // R4
  conv_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !bc_o && !rdy_line_i) |=> !busy_o);

  // R9
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt_i && busy_o && !bc_o) |=> !bc_o);

  // R9
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt_i && busy_o) |=> ovr_o);

  // R10
  ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_o && !ovr_clr_i) |=> ovr_o);
endmodule

// File: rtl/cbb_rdmux.sv
module cbb_rdmux
  import cbb_pkg::*;
#(
  parameter int DATA_W     = 10,
  parameter int BUS_W      = 8,
  parameter bit RIGHT_JUST = 1'b0
) (
  input  logic              sel_stat_i,
  input  logic              sel_hi_i,
  input  logic              sel_lo_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              rdy_line_i,
  input  logic              ovr_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic              oe_o
);
  localparam int LO_W = DATA_W - BUS_W;

  logic [BUS_W-1:0] hi_word, lo_word, stat_word;

  generate
    if (RIGHT_JUST) begin : g_right
      assign hi_word = {{(BUS_W-LO_W){1'b0}}, data_i[DATA_W-1 -: LO_W]};
      assign lo_word = data_i[BUS_W-1:0];
    end else begin : g_left
      assign hi_word = data_i[DATA_W-1 -: BUS_W];
      assign lo_word = {data_i[LO_W-1:0], {(BUS_W-LO_W){1'b0}}};
    end
  endgenerate

  always_comb begin
    stat_word               = '0;
    stat_word[STAT_RDY_BIT] = rdy_line_i;
    stat_word[STAT_OVR_BIT] = ovr_i;
  end

  always_comb begin
    rdata_o = '0;
    if (sel_stat_i)    rdata_o = stat_word;
    else if (sel_hi_i) rdata_o = hi_word;
    else if (sel_lo_i) rdata_o = lo_word;
  end

  assign oe_o = sel_stat_i || sel_hi_i || sel_lo_i;
endmodule

// File: rtl/conv_bus_bridge.sv
module conv_bus_bridge #(
  parameter int DATA_W      = 10,
  parameter int BUS_W       = 8,
  parameter int MIN_PULSE   = 8,
  parameter int SYNC_STAGES = 2,
  parameter bit RIGHT_JUST  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd_n,
  input  logic              bus_wr_n,
  input  logic              sel_start_n,
  input  logic              sel_hi_n,
  input  logic              sel_lo_n,
  input  logic              sel_stat_n,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              bus_oe,
  output logic              cvt_bc,
  input  logic              cvt_rdy_n,
  input  logic [DATA_W-1:0] cvt_data
);
  logic wr_act, wr_act_q, start_evt;
  logic rd_act, s_stat, s_hi, s_lo;
  logic stat_q, ovr_clr;
  logic rdy_line, busy, ovr;

  // Start strobe: one event per write access to the start address
  assign wr_act    = !sel_start_n && !bus_wr_n;
  assign start_evt = wr_act && !wr_act_q;

  // Read decode with status > high > low priority
  assign rd_act = !bus_rd_n;
  assign s_stat = rd_act && !sel_stat_n;
  assign s_hi   = rd_act && sel_stat_n && !sel_hi_n;
  assign s_lo   = rd_act && sel_stat_n && sel_hi_n && !sel_lo_n;

  // The overrun flag clears once a status read has ended
  assign ovr_clr = stat_q && !s_stat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_act_q <= 1'b0;
      stat_q   <= 1'b0;
    end else begin
      wr_act_q <= wr_act;
      stat_q   <= s_stat;
    end
  end

  cbb_sync #(
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b0)
  ) u_rdy_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (cvt_rdy_n),
    .q_o   (rdy_line)
  );

  cbb_launch #(
    .MIN_PULSE (MIN_PULSE)
  ) u_launch (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_evt_i (start_evt),
    .rdy_line_i  (rdy_line),
    .ovr_clr_i   (ovr_clr),
    .bc_o        (cvt_bc),
    .busy_o      (busy),
    .ovr_o       (ovr)
  );

  cbb_rdmux #(
    .DATA_W     (DATA_W),
    .BUS_W      (BUS_W),
    .RIGHT_JUST (RIGHT_JUST)
  ) u_rdmux (
    .sel_stat_i (s_stat),
    .sel_hi_i   (s_hi),
    .sel_lo_i   (s_lo),
    .data_i     (cvt_data),
    .rdy_line_i (rdy_line),
    .ovr_i      (ovr),
    .rdata_o    (bus_rdata),
    .oe_o       (bus_oe)
  );

  // R11
  bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_n || (sel_stat_n && sel_hi_n && sel_lo_n)) |-> (!bus_oe && bus_rdata == '0));

  // R8
  stat_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd_n && !sel_stat_n) |-> (bus_rdata[BUS_W-2:1] == '0));

  // R1
  idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy) |-> !cvt_bc);
endmodule

// File: tb/sim_conv_bus_bridge.sv
module sim_conv_bus_bridge;
  localparam int CLK_P     = 10;
  localparam int MIN_PULSE = 8;
  localparam int CONV_CYC  = 30;

  logic       clk, rst_n;
  logic       bus_rd_n, bus_wr_n, sel_start_n, sel_hi_n, sel_lo_n, sel_stat_n;
  logic [7:0] rdata0, rdata1;
  logic       oe0, oe1, cvt_bc, bc1;
  logic       cvt_rdy_n;
  logic [9:0] cvt_data;
  logic [9:0] next_code;
  int         rdy_dly;

  int n_chk, n_fail;

  conv_bus_bridge #(.MIN_PULSE(MIN_PULSE), .RIGHT_JUST(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .sel_start_n(sel_start_n), .sel_hi_n(sel_hi_n), .sel_lo_n(sel_lo_n),
    .sel_stat_n(sel_stat_n), .bus_rdata(rdata0), .bus_oe(oe0),
    .cvt_bc(cvt_bc), .cvt_rdy_n(cvt_rdy_n), .cvt_data(cvt_data));

  conv_bus_bridge #(.MIN_PULSE(MIN_PULSE), .RIGHT_JUST(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .sel_start_n(sel_start_n), .sel_hi_n(sel_hi_n), .sel_lo_n(sel_lo_n),
    .sel_stat_n(sel_stat_n), .bus_rdata(rdata1), .bus_oe(oe1),
    .cvt_bc(bc1), .cvt_rdy_n(cvt_rdy_n), .cvt_data(cvt_data));

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // Converter model: data-ready rises rdy_dly clocks after blanking starts.
  // The result appears CONV_CYC clocks after blank/convert falls.
  initial begin
    cvt_rdy_n = 1'b0;
    cvt_data  = '0;
    forever begin
      wait (cvt_bc === 1'b1);
      repeat (rdy_dly) @(posedge clk);
      #1 cvt_rdy_n = 1'b1;
      wait (cvt_bc === 1'b0);
      repeat (CONV_CYC) @(posedge clk);
      #1 cvt_data = next_code;
      cvt_rdy_n = 1'b0;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Scoreboard of read results
  logic [7:0] q_e0[$];
  logic [7:0] q_e1[$];
  string      q_tag[$];
  event       mon_ev;

  always @(mon_ev) begin
    logic [7:0] e0, e1;
    string t;
    e0 = q_e0.pop_front();
    e1 = q_e1.pop_front();
    t  = q_tag.pop_front();
    chk(oe0 === 1'b1 && rdata0 === e0, {t, " left"},  {oe0, 7'd0, rdata0}, {8'h80, e0});
    chk(oe1 === 1'b1 && rdata1 === e1, {t, " right"}, {oe1, 7'd0, rdata1}, {8'h80, e1});
  end

  // which: 0 status, 1 high, 2 low, 3 high and low together
  task automatic bus_read(input int which, input logic [7:0] e0, input logic [7:0] e1, input string tag);
    @(negedge clk);
    sel_stat_n = (which != 0);
    sel_hi_n   = !(which == 1 || which == 3);
    sel_lo_n   = !(which == 2 || which == 3);
    bus_rd_n   = 1'b0;
    q_e0.push_back(e0);
    q_e1.push_back(e1);
    q_tag.push_back(tag);
    #1 -> mon_ev;
    @(negedge clk);
    bus_rd_n = 1'b1; sel_stat_n = 1'b1; sel_hi_n = 1'b1; sel_lo_n = 1'b1;
  endtask

  task automatic read_result(input logic [9:0] c);
    bus_read(1, c[9:2], {6'd0, c[9:8]}, "R5 R7 high word");
    bus_read(2, {c[1:0], 6'd0}, c[7:0], "R6 R7 low word");
  endtask

  // Launch a start and measure the blank/convert pulse
  task automatic do_start(input logic [9:0] code);
    int width;
    logic rdy_at_fall;
    next_code = code;
    @(negedge clk);
    sel_start_n = 1'b0; bus_wr_n = 1'b0;
    @(negedge clk);
    chk(cvt_bc === 1'b1, "R2 launch after one edge", {15'd0, cvt_bc}, 16'd1);
    @(negedge clk);
    chk(cvt_bc === 1'b1, "R2 held strobe no relaunch", {15'd0, cvt_bc}, 16'd1);
    sel_start_n = 1'b1; bus_wr_n = 1'b1;
    width = 2;
    rdy_at_fall = 1'b0;
    while (cvt_bc === 1'b1) begin
      rdy_at_fall = cvt_rdy_n;
      @(negedge clk);
      if (cvt_bc === 1'b1) width++;
    end
    chk(width >= MIN_PULSE, "R3 pulse width", 16'(width), 16'(MIN_PULSE));
    chk(rdy_at_fall === 1'b1, "R3 falls after ready high", {15'd0, rdy_at_fall}, 16'd1);
  endtask

  task automatic wait_done();
    wait (cvt_rdy_n === 1'b0);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    n_chk = 0; n_fail = 0;
    rdy_dly = 3; next_code = '0;
    bus_rd_n = 1'b1; bus_wr_n = 1'b1;
    sel_start_n = 1'b1; sel_hi_n = 1'b1; sel_lo_n = 1'b1; sel_stat_n = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(cvt_bc === 1'b0, "R1 bc in reset", {15'd0, cvt_bc}, 16'd0);
    chk(oe0 === 1'b0 && rdata0 === 8'h00, "R1 bus idle in reset", {7'd0, oe0, rdata0}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cvt_bc === 1'b0, "R1 bc after reset", {15'd0, cvt_bc}, 16'd0);
    bus_read(0, 8'h00, 8'h00, "R1 R8 status after reset");

    // R11: strobes without a full select/read pair
    @(negedge clk);
    sel_hi_n = 1'b0;
    #1 chk(oe0 === 1'b0 && rdata0 === 8'h00, "R11 select without read", {7'd0, oe0, rdata0}, 16'd0);
    @(negedge clk);
    sel_hi_n = 1'b1; bus_rd_n = 1'b0;
    #1 chk(oe0 === 1'b0 && rdata0 === 8'h00, "R11 read without select", {7'd0, oe0, rdata0}, 16'd0);
    @(negedge clk);
    bus_rd_n = 1'b1;

    // Normal conversions, short ready delay: the minimum width governs
    do_start(10'h2D5);
    wait_done();
    bus_read(0, 8'h00, 8'h00, "R4 R8 status done");
    read_result(10'h2D5);
    bus_read(3, 8'hB5, 8'h02, "R11 high wins over low");

    // Long ready delay: the ready line governs the width (R4 restart)
    rdy_dly = 14;
    do_start(10'h3FF);
    wait_done();
    read_result(10'h3FF);
    rdy_dly = 3;
    do_start(10'h000);
    wait_done();
    read_result(10'h000);

    // R8: status while the converter has data-ready high during the conversion
    do_start(10'h201);
    repeat (4) @(negedge clk);
    bus_read(0, 8'h80, 8'h80, "R8 status busy ready high");
    // R9: start while busy is ignored
    @(negedge clk);
    sel_start_n = 1'b0; bus_wr_n = 1'b0;
    @(negedge clk);
    chk(cvt_bc === 1'b0, "R9 busy start ignored", {15'd0, cvt_bc}, 16'd0);
    sel_start_n = 1'b1; bus_wr_n = 1'b1;
    @(negedge clk);
    chk(cvt_bc === 1'b0, "R9 bc stays low", {15'd0, cvt_bc}, 16'd0);
    wait_done();
    read_result(10'h201);
    bus_read(0, 8'h01, 8'h01, "R9 overrun set");
    bus_read(0, 8'h00, 8'h00, "R10 overrun cleared by status read");

    // R10: clear and set at the same edge, set wins
    do_start(10'h155);
    repeat (2) @(negedge clk);
    sel_stat_n = 1'b0; bus_rd_n = 1'b0;
    repeat (2) @(negedge clk);
    bus_rd_n = 1'b1; sel_stat_n = 1'b1;
    sel_start_n = 1'b0; bus_wr_n = 1'b0;
    @(negedge clk);
    sel_start_n = 1'b1; bus_wr_n = 1'b1;
    chk(cvt_bc === 1'b0, "R9 R10 simultaneous start ignored", {15'd0, cvt_bc}, 16'd0);
    wait_done();
    bus_read(0, 8'h01, 8'h01, "R10 set wins over clear");
    bus_read(0, 8'h00, 8'h00, "R10 cleared afterwards");
    read_result(10'h155);

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule